// File: doc/BRIEF.md
# Reorder Buffer with Precise Exceptions

This block is the in-order retirement queue of an out-of-order core. Instructions enter at the tail in program order, each carrying its PC and the architectural register it will write. The slot number returned on allocation is the rename tag. Execution units later report each instruction's result, and may report them in any order. A report can also carry a fault flag.

The block retires from the head, one instruction per cycle at most, and only once that instruction has reported. A clean head is presented on the commit port for the architectural register file to write, and its slot is then freed. A faulting head is never presented on the commit port. The block instead raises a one-cycle flush that carries the faulting PC and the handler address. At the next clock edge it discards every entry, including any younger instructions that have already finished. The effect is that a fault is taken precisely: every older instruction has already been committed, and no younger one is ever committed.

Top module: `rob_core`

## Requirements
- R1: After synchronous reset the queue is empty: alloc_ready is 1, alloc_tag is 0, and commit_valid and flush_valid are 0.
- R2: An accepted allocation (alloc_valid and alloc_ready both high at a clock edge) takes the slot shown on alloc_tag. Tags are handed out 0, 1, …, DEPTH-1 and then wrap back to 0, in program order.
- R3: Once DEPTH entries are live and none has retired, alloc_ready is 0. A request made in that state is ignored, and alloc_tag does not change.
- R4: A writeback (wb_valid) to a slot that is live and still waiting stores wb_value and wb_fault, and marks the slot done. A writeback to a free slot, or to a slot that is already done, has no effect.
- R5: When the head slot is done without a fault, commit_valid is 1 and the port shows that slot's pc, destination and value. The slot is freed at the next edge. At most one entry commits per cycle.
- R6: Entries that are done but sit behind a head that is not done wait. Commits always leave in allocation order, whatever order the writebacks arrived in.
- R7: When the head slot is done with the fault flag set, flush_valid is 1, flush_epc equals the head PC, and flush_target equals the HANDLER_PC parameter (default 0x80). commit_valid is 0 in that cycle.
- R8: At the edge that ends a flush cycle, every entry is discarded. In the next cycle alloc_tag is 0 and alloc_ready is 1. No entry younger than the faulting one is ever committed.
- R9: Several live entries may name the same destination register. Each commits separately, in allocation order.
- R10: During a flush cycle alloc_ready is 0, and allocation requests and writebacks are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_pc | input | PC_W | PC of the instruction being allocated |
| alloc_dest | input | REG_W | Architectural destination register |
| alloc_ready | output | 1 | Allocation will be accepted this cycle |
| alloc_tag | output | TAG_W | Slot (rename tag) given to the request |
| wb_valid | input | 1 | Result report |
| wb_tag | input | TAG_W | Slot being reported |
| wb_value | input | DATA_W | Result value |
| wb_fault | input | 1 | Instruction raised an exception |
| commit_valid | output | 1 | Head retires; register file writes this cycle |
| commit_pc | output | PC_W | PC of retiring entry |
| commit_dest | output | REG_W | Register written |
| commit_value | output | DATA_W | Value written |
| flush_valid | output | 1 | Faulting head; squash and redirect |
| flush_epc | output | PC_W | PC of faulting instruction |
| flush_target | output | PC_W | Handler address |

## Verification
The embedded assertions check, on every cycle, several structural rules. Occupancy never exceeds DEPTH, and the pointer gap always matches the count. Commit and flush are never raised together. Each commit advances the head by exactly one. A flush leaves the queue empty and never lasts two cycles. An allocation only ever lands on a free slot, and a refused request leaves the tail where it was.

Other properties need whole instruction streams and can only be shown by the bench's scenarios. These are that results retire in allocation order after writebacks arrive out of order, that stray writebacks are ignored, and that same-register writes are kept apart. The most important is that younger instructions which finished before an older faulting divide never reach the register file.

// File: rtl/rob_pkg.sv
// Shared types for the reorder buffer.
// Assumes: nothing beyond standard SystemVerilog.
package rob_pkg;

    // Life cycle of one queue slot
    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,   // not allocated
        SLOT_WAIT  = 2'd1,   // allocated, result outstanding
        SLOT_OK    = 2'd2,   // result present, no exception
        SLOT_FAULT = 2'd3    // instruction raised an exception
    } slot_state_e;

endpackage

// File: rtl/rob_ptr_ctrl.sv
// Head/tail/occupancy bookkeeping for the circular queue.
// Assumes: DEPTH is a power of two; the caller never asserts alloc_fire when
// full, nor commit_fire when empty; flush has priority over everything.
module rob_ptr_ctrl #(
    parameter int DEPTH = 8,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_fire,
    input  logic             commit_fire,
    input  logic             flush,
    output logic [TAG_W-1:0] head,
    output logic [TAG_W-1:0] tail,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    // Advance pointers and track occupancy
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (commit_fire) head <= head + TAG_W'(1);
            if (alloc_fire)  tail <= tail + TAG_W'(1);
            case ({alloc_fire, commit_fire})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    // Status flags from occupancy
    always_comb begin
        full  = (count == CNT_W'(DEPTH));
        empty = (count == '0);
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R3
    AST_PTR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        TAG_W'(tail - head) == TAG_W'(count)); // R2
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0 && head == '0 && tail == '0)); // R8

endmodule

// File: rtl/rob_slot_array.sv
// Per-slot storage: state, PC, destination and result, one register set per
// entry built by generate. Read port addressed by rd_idx (the head).
// Assumes: alloc_idx names a free slot; release_idx names the head.
module rob_slot_array
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int PC_W   = 32,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc_fire,
    input  logic [TAG_W-1:0]  alloc_idx,
    input  logic [PC_W-1:0]   alloc_pc,
    input  logic [REG_W-1:0]  alloc_dest,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_value,
    input  logic              wb_fault,
    input  logic              release_fire,
    input  logic [TAG_W-1:0]  rd_idx,
    output slot_state_e       rd_state,
    output logic [PC_W-1:0]   rd_pc,
    output logic [REG_W-1:0]  rd_dest,
    output logic [DATA_W-1:0] rd_value
);

    slot_state_e       state_arr [DEPTH];
    logic [PC_W-1:0]   pc_arr    [DEPTH];
    logic [REG_W-1:0]  dest_arr  [DEPTH];
    logic [DATA_W-1:0] value_arr [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        slot_state_e       st_q;
        logic [PC_W-1:0]   pc_q;
        logic [REG_W-1:0]  dest_q;
        logic [DATA_W-1:0] val_q;
        logic              hit_alloc, hit_wb, hit_rel;

        // Decode which operations address this slot
        always_comb begin
            hit_alloc = alloc_fire   && (alloc_idx == TAG_W'(i));
            hit_wb    = wb_valid     && (wb_tag    == TAG_W'(i)) && (st_q == SLOT_WAIT);
            hit_rel   = release_fire && (rd_idx    == TAG_W'(i));
        end

        // Slot state and payload update
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                st_q   <= SLOT_FREE;
                pc_q   <= '0;
                dest_q <= '0;
                val_q  <= '0;
            end else if (hit_rel) begin
                st_q <= SLOT_FREE;
            end else if (hit_alloc) begin
                st_q   <= SLOT_WAIT;
                pc_q   <= alloc_pc;
                dest_q <= alloc_dest;
                val_q  <= '0;
            end else if (hit_wb) begin
                st_q  <= wb_fault ? SLOT_FAULT : SLOT_OK;
                val_q <= wb_value;
            end
        end

        assign state_arr[i] = st_q;
        assign pc_arr[i]    = pc_q;
        assign dest_arr[i]  = dest_q;
        assign value_arr[i] = val_q;
    end

    // Head read port
    always_comb begin
        rd_state = state_arr[rd_idx];
        rd_pc    = pc_arr[rd_idx];
        rd_dest  = dest_arr[rd_idx];
        rd_value = value_arr[rd_idx];
    end

    AST_ALLOC_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_fire && !flush) |-> state_arr[alloc_idx] == SLOT_FREE); // R2
    AST_RELEASE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        release_fire |-> state_arr[rd_idx] == SLOT_OK); // R5

endmodule

// File: rtl/rob_retire_ctl.sv
// Retirement decision for the head slot: commit a clean result, or raise a
// flush with the handler redirect for a faulting one.
// Assumes: head fields come from the slot array read port.
module rob_retire_ctl
    import rob_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32,
    parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0080
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              empty,
    input  slot_state_e       head_state,
    input  logic [PC_W-1:0]   head_pc,
    input  logic [REG_W-1:0]  head_dest,
    input  logic [DATA_W-1:0] head_value,
    output logic              commit_valid,
    output logic [PC_W-1:0]   commit_pc,
    output logic [REG_W-1:0]  commit_dest,
    output logic [DATA_W-1:0] commit_value,
    output logic              flush_valid,
    output logic [PC_W-1:0]   flush_epc,
    output logic [PC_W-1:0]   flush_target
);

    // Choose between commit, flush or waiting
    always_comb begin
        commit_valid = !empty && (head_state == SLOT_OK);
        flush_valid  = !empty && (head_state == SLOT_FAULT);
        commit_pc    = head_pc;
        commit_dest  = head_dest;
        commit_value = head_value;
        flush_epc    = head_pc;
        flush_target = HANDLER_PC;
    end

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_valid && flush_valid)); // R7
    AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> !flush_valid && !commit_valid); // R8

endmodule

// File: rtl/rob_core.sv
// Reorder buffer top: in-order allocate, any-order writeback, in-order
// retire with precise exception flush.
// Assumes: DEPTH is a power of two; the register file writes on commit_valid.
module rob_core
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int PC_W   = 32,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32,
    parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0080,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [PC_W-1:0]   alloc_pc,
    input  logic [REG_W-1:0]  alloc_dest,
    output logic              alloc_ready,
    output logic [TAG_W-1:0]  alloc_tag,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_value,
    input  logic              wb_fault,
    output logic              commit_valid,
    output logic [PC_W-1:0]   commit_pc,
    output logic [REG_W-1:0]  commit_dest,
    output logic [DATA_W-1:0] commit_value,
    output logic              flush_valid,
    output logic [PC_W-1:0]   flush_epc,
    output logic [PC_W-1:0]   flush_target
);

    logic [TAG_W-1:0]  head_idx, tail_idx;
    logic [CNT_W-1:0]  occ;
    logic              q_full, q_empty, alloc_fire;
    slot_state_e       h_state;
    logic [PC_W-1:0]   h_pc;
    logic [REG_W-1:0]  h_dest;
    logic [DATA_W-1:0] h_value;

    // Allocation handshake, blocked when full or flushing
    always_comb begin
        alloc_ready = !q_full && !flush_valid;
        alloc_fire  = alloc_valid && alloc_ready;
        alloc_tag   = tail_idx;
    end

    rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .alloc_fire(alloc_fire), .commit_fire(commit_valid), .flush(flush_valid),
        .head(head_idx), .tail(tail_idx), .count(occ),
        .full(q_full), .empty(q_empty)
    );

    rob_slot_array #(.DEPTH(DEPTH), .PC_W(PC_W), .REG_W(REG_W), .DATA_W(DATA_W)) u_slots (
        .clk(clk), .rst_n(rst_n), .flush(flush_valid),
        .alloc_fire(alloc_fire), .alloc_idx(tail_idx),
        .alloc_pc(alloc_pc), .alloc_dest(alloc_dest),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value), .wb_fault(wb_fault),
        .release_fire(commit_valid), .rd_idx(head_idx),
        .rd_state(h_state), .rd_pc(h_pc), .rd_dest(h_dest), .rd_value(h_value)
    );

    rob_retire_ctl #(.PC_W(PC_W), .REG_W(REG_W), .DATA_W(DATA_W),
                     .HANDLER_PC(HANDLER_PC)) u_retire (
        .clk(clk), .rst_n(rst_n), .empty(q_empty),
        .head_state(h_state), .head_pc(h_pc), .head_dest(h_dest), .head_value(h_value),
        .commit_valid(commit_valid), .commit_pc(commit_pc), .commit_dest(commit_dest),
        .commit_value(commit_value), .flush_valid(flush_valid),
        .flush_epc(flush_epc), .flush_target(flush_target)
    );

    AST_COMMIT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |=> head_idx == TAG_W'($past(head_idx) + TAG_W'(1))); // R5
    AST_REFUSE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && !alloc_ready && !commit_valid && !flush_valid)
            |=> $stable(alloc_tag) && occ == CNT_W'(DEPTH)); // R3

endmodule

// File: tb/sim_rob_core.sv
`timescale 1ns/1ps
// Bench for rob_core: reference queue model plus directed corner cases.
module sim_rob_core;
    localparam int DEPTH = 8, PC_W = 32, REG_W = 5, DATA_W = 32, TAG_W = 3;
    localparam logic [31:0] HANDLER = 32'h0000_0080;

    logic clk = 0, rst_n = 0;
    logic av = 0, wv = 0, wf = 0;
    logic [PC_W-1:0] apc = '0;
    logic [REG_W-1:0] adest = '0;
    logic [TAG_W-1:0] wtag = '0;
    logic [DATA_W-1:0] wval = '0;
    logic alloc_ready, commit_valid, flush_valid;
    logic [TAG_W-1:0] alloc_tag;
    logic [PC_W-1:0] commit_pc, flush_epc, flush_target;
    logic [REG_W-1:0] commit_dest;
    logic [DATA_W-1:0] commit_value;

    always #4 clk = ~clk;  // 125 MHz

    rob_core u0 (
        .clk(clk), .rst_n(rst_n), .alloc_valid(av), .alloc_pc(apc), .alloc_dest(adest),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag), .wb_valid(wv), .wb_tag(wtag),
        .wb_value(wval), .wb_fault(wf), .commit_valid(commit_valid), .commit_pc(commit_pc),
        .commit_dest(commit_dest), .commit_value(commit_value), .flush_valid(flush_valid),
        .flush_epc(flush_epc), .flush_target(flush_target)
    );

    // Reference model
    logic              m_live [DEPTH], m_done [DEPTH], m_flt [DEPTH];
    logic [PC_W-1:0]   m_pc   [DEPTH];
    logic [REG_W-1:0]  m_dst  [DEPTH];
    logic [DATA_W-1:0] m_val  [DEPTH];
    int m_h = 0, m_t = 0, m_cnt = 0;
    logic [DATA_W-1:0] arf [32];   // built from observed commits
    int n_cmp = 0, n_bad = 0, n_commits = 0, n_flushes = 0;
    bit finished = 0;

    function automatic bit exp_flush();
        return m_cnt > 0 && m_done[m_h] && m_flt[m_h];
    endfunction
    function automatic bit exp_commit();
        return m_cnt > 0 && m_done[m_h] && !m_flt[m_h];
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < DEPTH; i++) begin
            m_live[i] = 0; m_done[i] = 0; m_flt[i] = 0;
            m_pc[i] = '0; m_dst[i] = '0; m_val[i] = '0;
        end
        m_h = 0; m_t = 0; m_cnt = 0;
    endtask

    // Compare outputs (state-only) against the model, then apply one edge
    task automatic cycle();
        bit fl, cm, wb_ok;
        fl = exp_flush(); cm = exp_commit();
        chk("R3/R10 alloc_ready", 64'(alloc_ready), 64'((m_cnt < DEPTH) && !fl));
        chk("R2 alloc_tag", 64'(alloc_tag), 64'(m_t));
        chk("R5 commit_valid", 64'(commit_valid), 64'(cm));
        chk("R7 flush_valid", 64'(flush_valid), 64'(fl));
        if (cm) begin
            chk("R5 commit_pc", 64'(commit_pc), 64'(m_pc[m_h]));
            chk("R9 commit_dest", 64'(commit_dest), 64'(m_dst[m_h]));
            chk("R6 commit_value", 64'(commit_value), 64'(m_val[m_h]));
        end
        if (fl) begin
            chk("R7 flush_epc", 64'(flush_epc), 64'(m_pc[m_h]));
            chk("R7 flush_target", 64'(flush_target), 64'(HANDLER));
        end
        if (commit_valid) begin arf[commit_dest] = commit_value; n_commits++; end
        if (flush_valid) n_flushes++;
        @(posedge clk);
        if (fl) model_clear();
        else begin
            wb_ok = wv && m_live[wtag] && !m_done[wtag];
            if (wb_ok) begin m_done[wtag] = 1; m_flt[wtag] = wf; m_val[wtag] = wval; end
            if (cm) begin m_live[m_h] = 0; m_done[m_h] = 0; m_h = (m_h + 1) % DEPTH; m_cnt--; end
            if (av && (m_cnt + (cm ? 1 : 0)) < DEPTH) begin
                m_live[m_t] = 1; m_done[m_t] = 0; m_flt[m_t] = 0;
                m_pc[m_t] = apc; m_dst[m_t] = adest; m_val[m_t] = '0;
                m_t = (m_t + 1) % DEPTH; m_cnt++;
            end
        end
        @(negedge clk);
    endtask

    task automatic drive(bit a, logic [PC_W-1:0] pc, logic [REG_W-1:0] d,
                         bit w, logic [TAG_W-1:0] tg, logic [DATA_W-1:0] v, bit f);
        av = a; apc = pc; adest = d; wv = w; wtag = tg; wval = v; wf = f;
        cycle();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(0, '0, '0, 0, '0, '0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int seed, fl0, c0;
        logic [DATA_W-1:0] keep5, keep6, keep7;
        seed = $urandom(32'd470);
        model_clear();
        for (int i = 0; i < 32; i++) arf[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1: reset state
        chk("R1 alloc_ready", 64'(alloc_ready), 64'd1);
        chk("R1 alloc_tag", 64'(alloc_tag), 64'd0);
        chk("R1 commit_valid", 64'(commit_valid), 64'd0);
        chk("R1 flush_valid", 64'(flush_valid), 64'd0);

        // R2/R3: fill to full, then a refused request
        for (int i = 0; i < DEPTH; i++) drive(1, 32'h1000 + i * 4, 5'(i + 1), 0, '0, '0, 0);
        chk("R3 full refuses", 64'(alloc_ready), 64'd0);
        drive(1, 32'hDEAD, 5'd9, 0, '0, '0, 0);
        chk("R3 tag unchanged", 64'(alloc_tag), 64'd0);

        // R6/R4: writebacks out of order; head not done so nothing commits
        drive(0, '0, '0, 1, 3'd3, 32'h33, 0);
        drive(0, '0, '0, 1, 3'd1, 32'h11, 0);
        chk("R6 wait on head", 64'(commit_valid), 64'd0);
        drive(0, '0, '0, 1, 3'd1, 32'hBAD, 0);   // R4 already done: ignored
        drive(0, '0, '0, 1, 3'd2, 32'h22, 0);
        drive(0, '0, '0, 1, 3'd0, 32'h00, 0);
        for (int i = 4; i < DEPTH; i++) drive(0, '0, '0, 1, 3'(i), 32'(i * 16), 0);
        idle(10);
        chk("R4 second wb ignored", 64'(arf[2]), 64'h11);
        chk("R6 drained", 64'(alloc_tag), 64'd0);

        // R9: same destination three times
        for (int i = 0; i < 3; i++) drive(1, 32'h2000 + i * 4, 5'd12, 0, '0, '0, 0);
        drive(0, '0, '0, 1, 3'd2, 32'hC2, 0);
        drive(0, '0, '0, 1, 3'd0, 32'hC0, 0);
        drive(0, '0, '0, 1, 3'd1, 32'hC1, 0);
        idle(6);
        chk("R9 last writer wins", 64'(arf[12]), 64'hC2);

        // R8/R10: younger finish before an older faulting divide
        arf[5] = 32'h55; arf[6] = 32'h66; arf[7] = 32'h77;
        keep5 = arf[5]; keep6 = arf[6]; keep7 = arf[7];
        fl0 = n_flushes; c0 = n_commits;
        drive(1, 32'h3000, 5'd4, 0, '0, '0, 0);        // divide at tag 3
        drive(1, 32'h3004, 5'd5, 0, '0, '0, 0);
        drive(1, 32'h3008, 5'd6, 0, '0, '0, 0);
        drive(1, 32'h300C, 5'd7, 0, '0, '0, 0);
        drive(0, '0, '0, 1, 3'd6, 32'hA7, 0);
        drive(0, '0, '0, 1, 3'd4, 32'hA5, 0);
        drive(0, '0, '0, 1, 3'd5, 32'hA6, 0);
        drive(0, '0, '0, 1, 3'd3, 32'hEE, 1);
        chk("R7 flush raised", 64'(flush_valid), 64'd1);
        drive(1, 32'h4444, 5'd8, 1, 3'd6, 32'hFF, 0);  // R10 ignored in flush
        chk("R8 emptied tag", 64'(alloc_tag), 64'd0);
        chk("R8 ready after flush", 64'(alloc_ready), 64'd1);
        idle(4);
        chk("R8 one flush", 64'(n_flushes - fl0), 64'd1);
        chk("R8 no younger commit", 64'(n_commits - c0), 64'd0);
        chk("R8 r5 kept", 64'(arf[5]), 64'(keep5));
        chk("R8 r6 kept", 64'(arf[6]), 64'(keep6));
        chk("R8 r7 kept", 64'(arf[7]), 64'(keep7));
        chk("R10 no alloc in flush", 64'(commit_valid), 64'd0);

        // Constrained random traffic
        for (int k = 0; k < 3000; k++) begin
            logic [TAG_W-1:0] tg;
            tg = 3'($urandom % DEPTH);
            drive(($urandom % 3) != 0, $urandom, 5'($urandom % 32),
                  ($urandom % 4) != 0, tg, $urandom, ($urandom % 24) == 0);
        end
        idle(12);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule